// File: doc/BRIEF.md
# Platform-Level Interrupt Controller (single context)

This block collects up to 31 external interrupt inputs, numbered 1 to 31, and drives a single external-interrupt line to one processor context. Every source has a 3-bit priority, an enable bit and a trigger-type bit. With the trigger-type bit set, the source latches rising edges. With it clear, the source samples its input as a level. A source counts as eligible when it is pending, enabled and not in service. The line goes high when at least one eligible source has a priority strictly above a programmable threshold.

Software programs the block through a simple 32-bit register bus and services interrupts in two steps. A read of the claim/complete word returns the ID of the best eligible source and puts that source in service. A later write of the same ID to that word ends the service. While a source is in service, the block never offers it again. An edge source still records new rising edges during service and presents them once service ends. A level source samples its input again once service ends.

Register reads return data combinationally in the same cycle as the read strobe. The side effect of a claim read takes place at the clock edge that ends the read cycle.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, all priorities, enable bits, trigger-type bits and the threshold read as 0, a claim read returns 0, and `irq_out` is low.
- R2: Each priority word sits at byte address 4*n for source n. A write stores the written value, reduced to 7 when it is larger than 7, and a read returns the stored value.
- R3: Source 0 is reserved. Its priority word at address 0x0 always reads 0. Bit 0 of the enable word (0x2000) and of the trigger-type word (0x1080) always reads 0, whatever value was written.
- R4: `irq_out` is high exactly when some source is pending, enabled, not in service, and has a priority strictly greater than the threshold.
- R5: A read of the claim/complete word (0x200004) returns the eligible source with the highest priority above the threshold. Among sources of equal priority, the lowest ID wins. The read returns 0 when no source qualifies.
- R6: A claim read that returns a nonzero ID clears that source's pending state and puts it in service. The source is not returned again until its ID is written to 0x200004.
- R7: A level source (trigger-type bit 0) takes its pending state from its input one clock after the input changes, provided it is not in service. After completion it samples its input again, so an input that is still high is claimable again and an input that is low is not.
- R8: An edge source (trigger-type bit 1) becomes pending on a rising edge of its input, including an edge that arrives while the source is in service. Such an edge is offered right after completion. An input held high gives only one claim.
- R9: A completion write carrying an ID that is not in service, is 0, or is above 31 (compared on all 32 bits) has no effect.
- R10: The threshold word (0x200000) stores the written value, reduced to 7 when it is larger than 7, and reads back the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 22 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; a claim read has a side effect at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address and state |
| src_in | input | 31 | Interrupt inputs, bit n is source n (bits 31:1) |
| irq_out | output | 1 | External-interrupt request to the processor |

## Verification
The in-service and pending flags are the state that matters most, and neither is visible directly. A wrong in-service flag shows at the very next claim read: a source is returned twice, or a completed source never returns. A wrong pending flag for a level source shows one clock after its input moves, on `irq_out` and in the claim value. A lost edge shows only after completion, so the bench claims, completes, and claims again. It runs these steps against an arithmetic model over a sweep of thresholds, priority rotations and enable masks, and the equal-priority cases in that sweep check the tie rule.

// File: rtl/pic_pkg.sv
// Package: shared register offsets for the interrupt controller.
// Assumes a byte-addressed bus of at most 22 address bits.
package pic_pkg;
    localparam int OFF_PRIO  = 32'h0000_0000;
    localparam int OFF_TRIG  = 32'h0000_1080;
    localparam int OFF_EN    = 32'h0000_2000;
    localparam int OFF_THR   = 32'h0020_0000;
    localparam int OFF_CLAIM = 32'h0020_0004;
endpackage

// File: rtl/pic_gateway.sv
// Per-source gateway: turns one raw input into a pending flag and
// tracks whether the source is in service between claim and complete.
// Assumes claim only arrives while the source is eligible.
module pic_gateway (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic is_edge,
    input  logic claim,
    input  logic complete,
    output logic pending,
    output logic in_service
);
    logic src_q;
    logic rise;

    assign rise = src & ~src_q;

    // Remember the previous input level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= 1'b0;
        else        src_q <= src;
    end

    // In-service flag: set by a claim, cleared by a matching completion.
    always_ff @(posedge clk) begin
        if (!rst_n)        in_service <= 1'b0;
        else if (claim)    in_service <= 1'b1;
        else if (complete) in_service <= 1'b0;
    end

    // Pending: edge sources latch edges always; level sources follow input when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                   pending <= 1'b0;
        else if (is_edge)             pending <= (pending & ~claim) | rise;
        else if (in_service || claim) pending <= 1'b0;
        else                          pending <= src;
    end
endmodule

// File: rtl/pic_arbiter.sv
// Arbiter: picks the eligible source with the highest priority strictly
// above the threshold; a lower ID wins a tie. Purely combinational.
// Assumes bit 0 of the eligible vector is never set.
module pic_arbiter #(
    parameter int NSRC   = 31,
    parameter int PRIO_W = 3,
    parameter int IDX_W  = 5
) (
    input  logic [NSRC:0]              elig,
    input  logic [NSRC:0][PRIO_W-1:0]  prio,
    input  logic [PRIO_W-1:0]          thr,
    output logic [IDX_W-1:0]           best_id,
    output logic                       any
);
    logic [PRIO_W-1:0] best_p;

    // Linear scan: strict comparison keeps the first (lowest) ID on ties.
    always_comb begin
        best_id = '0;
        best_p  = thr;
        for (int i = 1; i <= NSRC; i++) begin
            if (elig[i] && (prio[i] > best_p)) begin
                best_p  = prio[i];
                best_id = IDX_W'(i);
            end
        end
        any = (best_id != '0);
    end
endmodule

// File: rtl/pic_regs.sv
// Register file: priorities, enable and trigger-type bitmaps, threshold,
// with address decode and read mux for all words except claim/complete.
// Assumes NSRC <= 31 so each bitmap fits in one 32-bit word.
module pic_regs
    import pic_pkg::*;
#(
    parameter int NSRC     = 31,
    parameter int PRIO_W   = 3,
    parameter int MAX_PRIO = 7,
    parameter int ADDR_W   = 22,
    parameter int IDX_W    = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_we,
    input  logic [31:0]                bus_wdata,
    output logic [NSRC:0][PRIO_W-1:0]  prio_o,
    output logic [NSRC:0]              en_o,
    output logic [NSRC:0]              edge_o,
    output logic [PRIO_W-1:0]          thr_o,
    output logic                       claim_sel,
    output logic [31:0]                cfg_rdata
);
    localparam logic [ADDR_W-1:0] A_PRIO_END = ADDR_W'(OFF_PRIO + 4 * (NSRC + 1));
    localparam logic [ADDR_W-1:0] A_TRIG     = ADDR_W'(OFF_TRIG);
    localparam logic [ADDR_W-1:0] A_EN       = ADDR_W'(OFF_EN);
    localparam logic [ADDR_W-1:0] A_THR      = ADDR_W'(OFF_THR);
    localparam logic [ADDR_W-1:0] A_CLAIM    = ADDR_W'(OFF_CLAIM);

    logic [PRIO_W-1:0] prio_q [1:NSRC];
    logic [NSRC:0]     en_q;
    logic [NSRC:0]     edge_q;
    logic [PRIO_W-1:0] thr_q;
    logic              sel_prio, sel_en, sel_trig, sel_thr;
    logic [IDX_W-1:0]  idx;
    logic [PRIO_W-1:0] wclamp;

    // Reduce an incoming value to the largest allowed priority.
    function automatic logic [PRIO_W-1:0] clamp(input logic [31:0] v);
        if (v > 32'(MAX_PRIO)) return PRIO_W'(MAX_PRIO);
        return v[PRIO_W-1:0];
    endfunction

    // Address decode for every word in the map.
    always_comb begin
        idx       = bus_addr[2 +: IDX_W];
        sel_prio  = (bus_addr[1:0] == 2'b00) && (bus_addr < A_PRIO_END);
        sel_en    = (bus_addr == A_EN);
        sel_trig  = (bus_addr == A_TRIG);
        sel_thr   = (bus_addr == A_THR);
        claim_sel = (bus_addr == A_CLAIM);
        wclamp    = clamp(bus_wdata);
    end

    // Per-source priority storage; source 0 has no storage at all.
    for (genvar g = 1; g <= NSRC; g++) begin : g_prio
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_q[g] <= '0;
            else if (bus_we && sel_prio && (idx == IDX_W'(g)))
                prio_q[g] <= wclamp;
        end
    end

    // Bitmaps and threshold; bit 0 of each bitmap is forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            edge_q <= '0;
            thr_q  <= '0;
        end else if (bus_we) begin
            if (sel_en)   en_q   <= {bus_wdata[NSRC:1], 1'b0};
            if (sel_trig) edge_q <= {bus_wdata[NSRC:1], 1'b0};
            if (sel_thr)  thr_q  <= wclamp;
        end
    end

    // Pack priorities into a vector with a zero entry for source 0.
    always_comb begin
        prio_o[0] = '0;
        for (int i = 1; i <= NSRC; i++) prio_o[i] = prio_q[i];
    end

    assign en_o   = en_q;
    assign edge_o = edge_q;
    assign thr_o  = thr_q;

    // Read mux for configuration words.
    always_comb begin
        cfg_rdata = '0;
        if (sel_prio)      cfg_rdata = 32'(prio_o[idx]);
        else if (sel_en)   cfg_rdata = 32'(en_q);
        else if (sel_trig) cfg_rdata = 32'(edge_q);
        else if (sel_thr)  cfg_rdata = 32'(thr_q);
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
// Top: single-context interrupt controller. Combines the register file,
// one gateway per source and the arbiter; handles claim reads and
// completion writes on the claim/complete word.
// Assumes the bus does not read and write in the same cycle (write wins).
module ext_irq_ctrl #(
    parameter int NSRC     = 31,
    parameter int PRIO_W   = 3,
    parameter int MAX_PRIO = 7,
    parameter int ADDR_W   = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NSRC:1]     src_in,
    output logic              irq_out
);
    localparam int IDX_W = $clog2(NSRC + 1);

    logic [NSRC:0][PRIO_W-1:0] prio;
    logic [NSRC:0]             en, is_edge, pend, claimed_vec, elig;
    logic [PRIO_W-1:0]         thr;
    logic                      claim_sel, claim_rd, complete_wr, any;
    logic [31:0]               cfg_rdata;
    logic [IDX_W-1:0]          best_id;

    pic_regs #(
        .NSRC(NSRC), .PRIO_W(PRIO_W), .MAX_PRIO(MAX_PRIO),
        .ADDR_W(ADDR_W), .IDX_W(IDX_W)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .prio_o(prio), .en_o(en), .edge_o(is_edge),
        .thr_o(thr), .claim_sel(claim_sel), .cfg_rdata(cfg_rdata)
    );

    // Claim happens on a read strobe alone; completion on a write strobe.
    assign claim_rd    = bus_re & ~bus_we & claim_sel;
    assign complete_wr = bus_we & claim_sel;

    assign pend[0]        = 1'b0;
    assign claimed_vec[0] = 1'b0;

    for (genvar g = 1; g <= NSRC; g++) begin : g_src
        pic_gateway i_gw (
            .clk(clk), .rst_n(rst_n), .src(src_in[g]), .is_edge(is_edge[g]),
            .claim(claim_rd && (best_id == IDX_W'(g))),
            .complete(complete_wr && (bus_wdata == 32'(g))),
            .pending(pend[g]), .in_service(claimed_vec[g])
        );
    end

    // A source competes only when pending, enabled and not in service.
    assign elig = pend & en & ~claimed_vec;

    pic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) i_arb (
        .elig(elig), .prio(prio), .thr(thr), .best_id(best_id), .any(any)
    );

    assign irq_out   = any;
    assign bus_rdata = claim_sel ? 32'(best_id) : cfg_rdata;
endmodule

// File: rtl/pic_checker.sv
// Checker: temporal properties on the controller's bus and service state.
// Attached to every instance of the top by the bind at the end of the file.
module pic_checker #(
    parameter int NSRC   = 31,
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_re,
    input logic [31:0]       bus_rdata,
    input logic              irq_out,
    input logic [NSRC:0]     claimed_vec
);
    localparam int IDX_W = $clog2(NSRC + 1);
    logic is_claim_rd;
    assign is_claim_rd = bus_re && !bus_we && (bus_addr == ADDR_W'(pic_pkg::OFF_CLAIM));

    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_out);

    p_empty_claim_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_claim_rd && !irq_out) |-> (bus_rdata == 32'd0));

    p_id_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        is_claim_rd |-> (bus_rdata <= 32'(NSRC)));

    p_irq_gives_id_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_claim_rd && irq_out) |-> (bus_rdata != 32'd0));

    p_no_reclaim_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_claim_rd && bus_rdata != 32'd0) |-> !claimed_vec[bus_rdata[IDX_W-1:0]]);

    p_claim_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_claim_rd && bus_rdata != 32'd0) |=> claimed_vec[$past(bus_rdata[IDX_W-1:0])]);
endmodule

bind ext_irq_ctrl pic_checker #(.NSRC(NSRC), .ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_rdata(bus_rdata), .irq_out(irq_out),
    .claimed_vec(claimed_vec)
);

// File: tb/test_ext_irq_ctrl.sv
module test_ext_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [21:0] A_TRIG = 22'h001080;
    localparam logic [21:0] A_EN   = 22'h002000;
    localparam logic [21:0] A_THR  = 22'h200000;
    localparam logic [21:0] A_CLM  = 22'h200004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [21:0] addr = '0;
    logic        we = 1'b0, re = 1'b0;
    logic [31:0] wdata = '0, rdata, d;
    logic [31:1] src = '0;
    logic        irq;
    int n_run = 0, n_fail = 0;
    bit done = 0;
    int p [32];
    bit en [32];
    bit cl [32];
    logic [31:0] enw;
    int best, bp;

    ext_irq_ctrl i_ext_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_re(re),
        .bus_wdata(wdata), .bus_rdata(rdata), .src_in(src), .irq_out(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
        n_run++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", r, a, e);
        end
    endtask

    task automatic wr(input logic [21:0] a, input logic [31:0] v);
        @(negedge clk); addr = a; wdata = v; we = 1'b1;
        @(posedge clk); #1; we = 1'b0;
    endtask

    task automatic rd(input logic [21:0] a, output logic [31:0] v);
        @(negedge clk); addr = a; re = 1'b1; #1; v = rdata;
        @(posedge clk); #1; re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic chk_irq(input string r, input logic e);
        @(negedge clk); #1; chk(r, {31'd0, irq}, {31'd0, e});
    endtask

    task automatic set_src(input int n, input logic v);
        @(negedge clk); src[n] = v;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        chk_irq("R1", 1'b0);
        for (int i = 0; i < 32; i++) begin
            rd(22'(4 * i), d); chk("R1", d, 0);
        end
        rd(A_EN, d);   chk("R1", d, 0);
        rd(A_TRIG, d); chk("R1", d, 0);
        rd(A_THR, d);  chk("R1", d, 0);
        rd(A_CLM, d);  chk("R1", d, 0);

        // R2: clamp sweep over every source and value
        for (int i = 1; i < 32; i++) begin
            wr(22'(4 * i), 32'((i * 5) % 16));
            rd(22'(4 * i), d);
            chk("R2", d, ((i * 5) % 16) > 7 ? 7 : (i * 5) % 16);
        end
        wr(22'(4), 32'hFFFF_FFF0); rd(22'(4), d); chk("R2", d, 7);

        // R3: reserved source 0
        wr(22'h0, 5); rd(22'h0, d); chk("R3", d, 0);
        wr(A_EN, 32'hFFFF_FFFF); rd(A_EN, d); chk("R3", d, 32'hFFFF_FFFE);
        wr(A_TRIG, 32'hFFFF_FFFF); rd(A_TRIG, d); chk("R3", d, 32'hFFFF_FFFE);
        wr(A_EN, 0); wr(A_TRIG, 0);

        // R10: threshold clamp
        wr(A_THR, 9); rd(A_THR, d); chk("R10", d, 7);
        wr(A_THR, 3); rd(A_THR, d); chk("R10", d, 3);

        // R4/R5/R6: arbitration sweep, level sources all high
        for (int thr = 0; thr < 8; thr++) begin
            for (int rot = 0; rot < 4; rot++) begin
                enw = '0;
                for (int i = 1; i < 32; i++) begin
                    p[i] = (i * 3 + rot * 5) % 8;
                    wr(22'(4 * i), 32'(p[i]));
                    en[i] = ((i + rot) % 5) != 0;
                    if (en[i]) enw[i] = 1'b1;
                    cl[i] = 0;
                end
                wr(A_EN, enw); wr(A_THR, 32'(thr)); wr(A_TRIG, 0);
                @(negedge clk); src = '1;
                idle(2);
                for (int k = 0; k < 32; k++) begin
                    best = 0; bp = thr;
                    for (int i = 1; i < 32; i++)
                        if (en[i] && !cl[i] && p[i] > bp) begin bp = p[i]; best = i; end
                    chk_irq("R4", best != 0);
                    rd(A_CLM, d); chk("R5", d, 32'(best));
                    if (best == 0) break;
                    cl[best] = 1;
                end
                @(negedge clk); src = '0;
                idle(2);
                for (int i = 1; i < 32; i++) if (cl[i]) wr(A_CLM, 32'(i));
                idle(2);
                rd(A_CLM, d); chk("R7", d, 0);
            end
        end

        // R6/R7: single level source
        for (int i = 1; i < 32; i++) wr(22'(4 * i), 0);
        wr(22'(4 * 5), 3); wr(A_EN, 32'h20); wr(A_THR, 0); wr(A_TRIG, 0);
        set_src(5, 1'b1); idle(2);
        chk_irq("R7", 1'b1);
        rd(A_CLM, d); chk("R6", d, 5);
        chk_irq("R6", 1'b0);
        rd(A_CLM, d); chk("R6", d, 0);
        wr(A_CLM, 5); idle(2);
        rd(A_CLM, d); chk("R7", d, 5);
        wr(A_CLM, 5); set_src(5, 1'b0); idle(2);
        rd(A_CLM, d); chk("R7", d, 0);

        // R9: ignored completions
        set_src(5, 1'b1); idle(2);
        rd(A_CLM, d); chk("R9", d, 5);
        wr(A_CLM, 6); wr(A_CLM, 0); wr(A_CLM, 37); idle(2);
        rd(A_CLM, d); chk("R9", d, 0);
        chk_irq("R9", 1'b0);
        wr(A_CLM, 5); idle(2);
        rd(A_CLM, d); chk("R9", d, 5);
        wr(A_CLM, 5); set_src(5, 1'b0); idle(2);

        // R8: edge source
        wr(22'(4 * 9), 2); wr(A_EN, 32'h200); wr(A_TRIG, 32'h200);
        set_src(9, 1'b1); set_src(9, 1'b0); idle(2);
        chk_irq("R8", 1'b1);
        rd(A_CLM, d); chk("R8", d, 9);
        rd(A_CLM, d); chk("R8", d, 0);
        set_src(9, 1'b1); set_src(9, 1'b0); idle(2);
        rd(A_CLM, d); chk("R8", d, 0);
        wr(A_CLM, 9); idle(1);
        rd(A_CLM, d); chk("R8", d, 9);
        wr(A_CLM, 9); idle(2);
        rd(A_CLM, d); chk("R8", d, 0);
        set_src(9, 1'b1); idle(2);
        rd(A_CLM, d); chk("R8", d, 9);
        wr(A_CLM, 9); idle(2);
        rd(A_CLM, d); chk("R8", d, 0);
        chk_irq("R8", 1'b0);
        set_src(9, 1'b0); idle(2);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule